// File: doc/BRIEF.md
# Manchester / Bi-phase Line Coder with Residual Bit Counter

This block turns a serial bit stream into a self-clocking line code. A timer supplies a single-cycle enable, `halfTick`, once per half-bit period, so the timer sets the bit rate. The coder drives one half-bit level per tick, in either Manchester or Bi-phase code. The mode is chosen at frame start.

Data arrives one byte at a time. The coder raises `dataReq` for one cycle whenever it needs a new byte. It captures `dataIn`, together with a flag marking the final byte, on that same clock edge. The byte feed only works in whole bytes, so a small residual counter trims the final byte to a programmed number of bits. This lets a frame have any length, not only a multiple of eight.

After the last half-bit the output falls back to a low idle level and a done flag is raised. The done flag stays high until the next frame is accepted.

Top module: `bitcode_mod`

## Requirements
- R1: While reset is asserted and right after it, `codeOut`, `done` and `dataReq` are all 0.
- R2: A `startReq` pulse seen while idle starts a frame. `codeOut` stays 0 until the first `halfTick` after the start. That tick drives the first half of the first bit.
- R3: `codeOut` changes only on the clock edge that samples `halfTick` high. Each tick advances the output by exactly one half-bit.
- R4: In Manchester mode (`codeSel` = 0), a 1 is sent as high then low, and a 0 is sent as low then high.
- R5: In Bi-phase mode (`codeSel` = 1), the level inverts at the start of every bit. It inverts again at mid-bit only when the bit is 1. Since idle is low, the first half of the first bit is high.
- R6: Bits leave MSB first, with `dataIn[7]` going first. `dataReq` is high only during the `halfTick` cycle that begins bit 0 of each byte. The byte and `lastByte` are captured on that edge.
- R7: For the byte loaded with `lastByte` = 1, only the top `lastBits` bits are sent, for values 1 to 8. A `lastBits` value of 0, or any value above 8, sends all 8 bits.
- R8: The tick after the last half-bit drives `codeOut` to 0 and sets `done`. `done` stays high until the edge after the next accepted start, which clears it.
- R9: A `startReq` received while a frame is running is ignored. The frame's bits, its mode and its length are unchanged.
- R10: `codeSel` is sampled only when a start is accepted. Changing it during a frame has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| halfTick | input | 1 | Half-bit-period enable from the rate timer |
| codeSel | input | 1 | 0 = Manchester, 1 = Bi-phase; sampled at start |
| startReq | input | 1 | Start-of-frame strobe |
| lastBits | input | 4 | Bits to send from the final byte (0 or >8 means 8) |
| dataIn | input | 8 | Next data byte, MSB sent first |
| lastByte | input | 1 | Marks `dataIn` as the final byte of the frame |
| dataReq | output | 1 | Byte-taken strobe; `dataIn` is captured on this edge |
| codeOut | output | 1 | Coded line output, idle low |
| done | output | 1 | Frame finished; held until the next accepted start |

## Verification
Every level on `codeOut` is registered on the edge that samples `halfTick` high, so it is due one edge after the tick is raised. The bench raises the tick on a falling edge and reads the new level on the next falling edge. It then reads again one cycle later to confirm that nothing moved between ticks. `dataReq` is combinational within the tick cycle, so the bench samples it 1 ns after raising `halfTick`, before the capturing edge. `done` and the return to idle are due on the edge of the tick that follows the final half-bit. The clearing of `done` is checked on the falling edge after the start pulse.

// File: rtl/lc_pkg.sv
package lc_pkg;

  // Strobes passed from the control FSM to the datapath, plus the latched mode level
  typedef struct packed {
    logic start;    // frame accepted: clear done
    logic load;     // take a fresh byte from dataIn
    logic shift;    // advance to the next bit of the held byte
    logic first;    // drive the first half of a bit
    logic second;   // drive the second half of a bit
    logic finish;   // return to idle level, raise done
    logic biphase;  // latched mode: 1 = Bi-phase, 0 = Manchester
  } strobe_t;

endpackage

// File: rtl/lc_control.sv
module lc_control
  import lc_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    halfTick,
  input  logic    startReq,
  input  logic    codeSel,
  input  logic    byteEnd,
  input  logic    frameEnd,
  output strobe_t strb,
  output logic    busy
);

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WAIT   = 2'd1,
    ST_FIRST  = 2'd2,
    ST_SECOND = 2'd3
  } state_t;

  state_t state, stateNext;
  logic   modeQ;

  always_comb begin
    stateNext    = state;
    strb         = '0;
    strb.biphase = modeQ;
    unique case (state)
      ST_IDLE: begin
        if (startReq) begin
          strb.start = 1'b1;
          stateNext  = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (halfTick) begin
          strb.load  = 1'b1;
          strb.first = 1'b1;
          stateNext  = ST_FIRST;
        end
      end
      ST_FIRST: begin
        if (halfTick) begin
          strb.second = 1'b1;
          stateNext   = ST_SECOND;
        end
      end
      ST_SECOND: begin
        if (halfTick) begin
          if (frameEnd) begin
            strb.finish = 1'b1;
            stateNext   = ST_IDLE;
          end else begin
            strb.load  = byteEnd;
            strb.shift = !byteEnd;
            strb.first = 1'b1;
            stateNext  = ST_FIRST;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      modeQ <= 1'b0;
    end else begin
      state <= stateNext;
      if (strb.start) modeQ <= codeSel;
    end
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/lc_datapath.sv
module lc_datapath
  import lc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              lastByte,
  input  logic [CNT_W-1:0]  lastBits,
  output logic              byteEnd,
  output logic              frameEnd,
  output logic              codeOut,
  output logic              done
);

  localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] LIMIT_CNT = CNT_W'(DATA_W + 1);

  logic [DATA_W-1:0] shReg;
  logic [CNT_W-1:0]  remQ;
  logic [CNT_W-1:0]  loadCount;
  logic              lastQ;
  logic              curBit;
  logic              nextBit;
  logic              outQ;
  logic              doneQ;

  // Bits to send from the byte being taken: full width unless it is the last one
  always_comb begin
    if (lastByte && (lastBits != '0) && (lastBits < LIMIT_CNT))
      loadCount = lastBits;
    else
      loadCount = FULL_CNT;
  end

  assign nextBit  = strb.load ? dataIn[DATA_W-1] : shReg[DATA_W-2];
  assign byteEnd  = (remQ == CNT_W'(1));
  assign frameEnd = byteEnd && lastQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg  <= '0;
      remQ   <= '0;
      lastQ  <= 1'b0;
      curBit <= 1'b0;
      outQ   <= 1'b0;
      doneQ  <= 1'b0;
    end else begin
      if (strb.start) doneQ <= 1'b0;

      if (strb.load) begin
        shReg <= dataIn;
        lastQ <= lastByte;
        remQ  <= loadCount;
      end else if (strb.shift) begin
        shReg <= {shReg[DATA_W-2:0], 1'b0};
        remQ  <= remQ - CNT_W'(1);
      end

      if (strb.first) begin
        curBit <= nextBit;
        outQ   <= strb.biphase ? ~outQ : nextBit;
      end

      if (strb.second) begin
        if (strb.biphase) outQ <= curBit ? ~outQ : outQ;
        else              outQ <= ~curBit;
      end

      if (strb.finish) begin
        outQ  <= 1'b0;
        doneQ <= 1'b1;
      end
    end
  end

  assign codeOut = outQ;
  assign done    = doneQ;

endmodule

// File: rtl/bitcode_mod.sv
module bitcode_mod
  import lc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              halfTick,
  input  logic              codeSel,
  input  logic              startReq,
  input  logic [CNT_W-1:0]  lastBits,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              lastByte,
  output logic              dataReq,
  output logic              codeOut,
  output logic              done
);

  strobe_t strb;
  logic    busy;
  logic    byteEnd;
  logic    frameEnd;

  lc_control u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .halfTick (halfTick),
    .startReq (startReq),
    .codeSel  (codeSel),
    .byteEnd  (byteEnd),
    .frameEnd (frameEnd),
    .strb     (strb),
    .busy     (busy)
  );

  lc_datapath #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .dataIn   (dataIn),
    .lastByte (lastByte),
    .lastBits (lastBits),
    .byteEnd  (byteEnd),
    .frameEnd (frameEnd),
    .codeOut  (codeOut),
    .done     (done)
  );

  assign dataReq = strb.load;

endmodule

// File: rtl/lc_checker.sv
module lc_checker
  import lc_pkg::*;
(
  input logic    clk,
  input logic    rstN,
  input logic    halfTick,
  input logic    startReq,
  input logic    dataReq,
  input logic    codeOut,
  input logic    done,
  input logic    busy,
  input strobe_t strb
);

  // R3: line level only moves on the edge after a tick
  a_r3_change_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    !$past(halfTick) |-> $stable(codeOut));

  // R6: a byte is taken only inside a tick of a running frame
  a_r6_req_in_tick: assert property (@(posedge clk) disable iff (!rstN)
    dataReq |-> (halfTick && busy));

  // R4: Manchester always inverts at mid-bit
  a_r4_mid_invert: assert property (@(posedge clk) disable iff (!rstN)
    (strb.second && !strb.biphase) |=> (codeOut != $past(codeOut)));

  // R5: Bi-phase always inverts at the bit boundary
  a_r5_edge_invert: assert property (@(posedge clk) disable iff (!rstN)
    (strb.first && strb.biphase) |=> (codeOut != $past(codeOut)));

  // R8: done appears with the idle-low level and an idle controller
  a_r8_done_idle_low: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> (!codeOut && !busy));

  // R8: done holds until a start arrives
  a_r8_done_hold: assert property (@(posedge clk) disable iff (!rstN)
    (done && !startReq) |=> done);

endmodule

bind bitcode_mod lc_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .halfTick (halfTick),
  .startReq (startReq),
  .dataReq  (dataReq),
  .codeOut  (codeOut),
  .done     (done),
  .busy     (busy),
  .strb     (strb)
);

// File: tb/tb_bitcode_mod.sv
module tb_bitcode_mod;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       halfTick = 1'b0;
  logic       codeSel = 1'b0;
  logic       startReq = 1'b0;
  logic [3:0] lastBits = 4'd0;
  logic [7:0] dataIn = 8'd0;
  logic       lastByte = 1'b0;
  logic       dataReq;
  logic       codeOut;
  logic       done;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  bitcode_mod dut (
    .clk(clk), .rstN(rstN), .halfTick(halfTick), .codeSel(codeSel),
    .startReq(startReq), .lastBits(lastBits), .dataIn(dataIn),
    .lastByte(lastByte), .dataReq(dataReq), .codeOut(codeOut), .done(done)
  );

  // {mode, byteCount[1:0], lastBits[3:0], byte0, byte1, byte2}
  localparam int NVEC = 7;
  localparam logic [30:0] VECS [NVEC] = '{
    {1'b0, 2'd1, 4'd8,  8'hA5, 8'h00, 8'h00},
    {1'b1, 2'd1, 4'd8,  8'hA5, 8'h00, 8'h00},
    {1'b0, 2'd2, 4'd3,  8'h3C, 8'hE0, 8'h00},
    {1'b1, 2'd3, 4'd5,  8'h81, 8'h7E, 8'hF8},
    {1'b0, 2'd1, 4'd1,  8'h80, 8'h00, 8'h00},
    {1'b1, 2'd2, 4'd0,  8'hFF, 8'h00, 8'h00},
    {1'b0, 2'd1, 4'd12, 8'h5A, 8'h00, 8'h00}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // Runs one frame; interruptAt >= 0 inserts a busy start with the opposite mode (R9, R10)
  task automatic runFrame(input logic mode, input int nB, input int lb,
                          input logic [23:0] bytes, input int interruptAt);
    int effLb, total, idx, reqs;
    logic lvl, b, expOut, r, o;
    effLb = (lb == 0 || lb > 8) ? 8 : lb;
    total = 8 * (nB - 1) + effLb;
    lastBits = 4'(lb);
    @(negedge clk);
    codeSel = mode; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    chk("R8 done cleared by start", int'(done), 0);
    chk("R2 idle low after start", int'(codeOut), 0);
    repeat (2) @(negedge clk);
    chk("R2 no output before first tick", int'(codeOut), 0);
    idx = 0; reqs = 0; lvl = 1'b0;
    for (int k = 0; k < total; k++) begin
      b = bytes[23 - k];
      for (int h = 0; h < 2; h++) begin
        if (interruptAt == 2 * k + h) begin
          @(negedge clk);
          startReq = 1'b1; codeSel = ~mode;
          @(negedge clk);
          startReq = 1'b0;
        end
        if (mode) begin
          if (h == 0) expOut = ~lvl;
          else        expOut = b ? ~lvl : lvl;
        end else begin
          expOut = (h == 0) ? b : ~b;
        end
        lvl = expOut;
        @(negedge clk);
        halfTick = 1'b1;
        dataIn   = (idx < 3) ? bytes[23 - 8 * idx -: 8] : 8'h00;
        lastByte = (idx == nB - 1);
        #1 r = dataReq;
        chk("R6 dataReq at byte start", int'(r), int'((k % 8 == 0) && (h == 0)));
        @(negedge clk);
        halfTick = 1'b0;
        if (r) begin idx++; reqs++; end
        o = codeOut;
        chk(mode ? "R5 biphase half level" : "R4 manchester half level", int'(o), int'(expOut));
        if (interruptAt >= 0) chk("R9 R10 busy start ignored", int'(o), int'(expOut));
        @(negedge clk);
        chk("R3 stable between ticks", int'(codeOut), int'(o));
      end
    end
    chk("R7 bytes requested", reqs, nB);
    chk("R8 done low before final tick", int'(done), 0);
    @(negedge clk);
    halfTick = 1'b1;
    @(negedge clk);
    halfTick = 1'b0;
    chk("R8 idle low after frame", int'(codeOut), 0);
    chk("R7 R8 done after last bit", int'(done), 1);
    repeat (3) @(negedge clk);
    chk("R8 done held", int'(done), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 codeOut in reset", int'(codeOut), 0);
    chk("R1 done in reset", int'(done), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 codeOut after reset", int'(codeOut), 0);
    chk("R1 done after reset", int'(done), 0);
    chk("R1 dataReq after reset", int'(dataReq), 0);

    // Ticks with no start leave the line idle (R2)
    halfTick = 1'b1;
    #1 chk("R2 no request while idle", int'(dataReq), 0);
    @(negedge clk);
    halfTick = 1'b0;
    chk("R2 no output without start", int'(codeOut), 0);

    for (int v = 0; v < NVEC; v++)
      runFrame(VECS[v][30], int'(VECS[v][29:28]), int'(VECS[v][27:24]), VECS[v][23:0], -1);

    // Directed: start while busy, with the mode flipped (R9, R10)
    runFrame(1'b1, 1, 8, {8'hC3, 16'h0000}, 5);
    runFrame(1'b0, 2, 2, {8'h96, 8'h40, 8'h00}, 9);

    finishRun();
  end

endmodule